// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a 16-bit up-counter with a single channel register that works in one of two roles. In the compare role the register holds a period. The counter is matched against a shadow buffer loaded from that register. Each match gives a one-cycle pulse, clears the counter and can invert a toggle output. The buffer can follow a write at once, or it can wait for a batch point, so a new period never cuts into a period that is already running. In the capture role a synchronized trigger input latches the counter into the same register. The counter either keeps running, which captures timestamps, or restarts from zero, which measures the width between edges.

The mode and the valid trigger edge are chosen by small select inputs. The register is always visible on the readback port. Every update of the register is one whole-word register load, so a readback is never a mix of old and new bits. Dropping the count enable stops and zeroes the counter. It empties the register in the capture role and leaves it intact in the compare role.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset, `rd_data` is 0, `match_pulse`, `cap_pulse` and `tog_out` are 0.
- R2: In mode 2'b00 (interval) and 2'b01 (batch period), the buffer is loaded from the register on the first enabled cycle. With buffer value N, `match_pulse` rises for one cycle every N+1 clocks, and the counter returns to 0 with each match.
- R3: On each match, `tog_out` inverts when `out_en` was 1 in the cycle before and holds when it was 0.
- R4: In mode 2'b00 a register write also loads the buffer at once, so the running period changes immediately.
- R5: In mode 2'b01 a write reaches `rd_data` at once, but the buffer loads only at a match that comes after a `batch_req` strobe; without a strobe the old period continues.
- R6: Deasserting `cnt_en` in a compare mode keeps the register value.
- R7: In mode 2'b10 (free capture), a valid edge copies the counter into the register, raises `cap_pulse` for one cycle, and the counter keeps running. Two edges K clocks apart give values that differ by K.
- R8: In mode 2'b11 (pulse width), a valid edge captures the counter and clears it. Two edges K clocks apart give K-1.
- R9: `edge_sel` encodes 2'b01 rising, 2'b10 falling, 2'b11 both and 2'b00 none. Edges that are not selected cause no capture.
- R10: Deasserting `cnt_en` in a capture mode clears the register to 0.
- R11: In free capture the counter wraps from 0xFFFF to 0x0000. Edges 65538 clocks apart give a difference of 2.
- R12: In pulse width mode a 65536-clock interval reads 0xFFFF, because the capture wins over the wrap.
- R13: In capture modes, register writes are ignored and `match_pulse` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable |
| mode | input | 2 | 00 interval, 01 batch period, 10 free capture, 11 pulse width |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| cap_in | input | 1 | Asynchronous capture trigger |
| edge_sel | input | 2 | Valid trigger edge select |
| batch_req | input | 1 | Batch-load strobe |
| out_en | input | 1 | Toggle output enable |
| rd_data | output | 16 | Register readback |
| match_pulse | output | 1 | Compare match pulse |
| cap_pulse | output | 1 | Capture pulse |
| tog_out | output | 1 | Toggle output |

## Verification
The compare role is run with several period values, and the gap between match pulses is measured. An anytime write and a batch write are then each placed right after a match. The two can only be told apart by the gap that follows: the anytime write changes the next gap, while the batch write waits for the strobe. Capture is driven with edge pairs of known spacing under each edge select and in both capture modes. Differences taken between captures do not depend on the synchronizer delay. Long intervals of 65536 and 65538 clocks show the wrap and the capture-over-wrap priority, and short pulses show the clear-on-disable split between the two roles.

// File: rtl/tmr_capcmp_pkg.sv
package tmr_capcmp_pkg;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_BATCH    = 2'b01,
        MODE_FREECAP  = 2'b10,
        MODE_PULSEW   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_capcmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] sel,
    output logic       edge_ev
);
    localparam int CHAIN = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;
    logic  cur, prev, rise, fall;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[CHAIN-2:0], trig_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.chain[CHAIN-2];
    assign prev = s_q.chain[CHAIN-1];
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        case (edge_sel_e'(sel))
            EDGE_RISE: edge_ev = rise;
            EDGE_FALL: edge_ev = fall;
            EDGE_BOTH: edge_ev = rise | fall;
            default:   edge_ev = 1'b0;
        endcase
    end

    assert_edge_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ev |-> (sel != 2'b00));

endmodule

// File: rtl/tmr_cmp_buffer.sv
module tmr_cmp_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_start,
    input  logic         load_now,
    input  logic         batch_mode,
    input  logic         period_hit,
    input  logic         batch_req,
    input  logic [W-1:0] reg_next,
    output logic [W-1:0] buf_val
);
    typedef struct packed {
        logic [W-1:0] bufv;
        logic         pend;
    } cbuf_t;

    cbuf_t b_d, b_q;
    logic  xfer, load;

    always_comb begin
        b_d  = b_q;
        xfer = batch_mode & period_hit & b_q.pend;
        load = load_start | load_now | xfer;
        if (load) b_d.bufv = reg_next;
        b_d.pend = batch_req | (b_q.pend & ~xfer);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign buf_val = b_q.bufv;

    assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.bufv != $past(b_q.bufv)) |-> $past(load));

endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
    import tmr_capcmp_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cap_in,
    input  logic [1:0]   edge_sel,
    input  logic         batch_req,
    input  logic         out_en,
    output logic [W-1:0] rd_data,
    output logic         match_pulse,
    output logic         cap_pulse,
    output logic         tog_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] regv;
        logic         en;
        logic         match;
        logic         cap;
        logic         tog;
    } core_t;

    core_t c_d, c_q;

    tmr_mode_e    md;
    logic         cap_role, pw_mode, batch_mode;
    logic         start, run, hit, cap_ev, edge_ev;
    logic [W-1:0] buf_val;

    assign md         = tmr_mode_e'(mode);
    assign cap_role   = (md == MODE_FREECAP) || (md == MODE_PULSEW);
    assign pw_mode    = (md == MODE_PULSEW);
    assign batch_mode = (md == MODE_BATCH);

    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (cap_in),
        .sel     (edge_sel),
        .edge_ev (edge_ev)
    );

    tmr_cmp_buffer #(.W(W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (start & ~cap_role),
        .load_now   (wr_en & (md == MODE_INTERVAL)),
        .batch_mode (batch_mode),
        .period_hit (hit),
        .batch_req  (batch_req),
        .reg_next   (c_d.regv),
        .buf_val    (buf_val)
    );

    always_comb begin
        c_d    = c_q;
        start  = cnt_en & ~c_q.en;
        run    = cnt_en & c_q.en;
        hit    = run & ~cap_role & (c_q.cnt == buf_val);
        cap_ev = run & cap_role & edge_ev;

        c_d.en    = cnt_en;
        c_d.match = hit;
        c_d.cap   = cap_ev;
        c_d.tog   = c_q.tog ^ (hit & out_en);

        // counter
        if (!cnt_en || start)        c_d.cnt = '0;
        else if (cap_ev && pw_mode)  c_d.cnt = '0;
        else if (hit)                c_d.cnt = '0;
        else                         c_d.cnt = c_q.cnt + 1'b1;

        // channel register
        if (cap_role) begin
            if (!cnt_en)     c_d.regv = '0;
            else if (cap_ev) c_d.regv = c_q.cnt;
        end else if (wr_en) begin
            c_d.regv = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data     = c_q.regv;
    assign match_pulse = c_q.match;
    assign cap_pulse   = c_q.cap;
    assign tog_out     = c_q.tog;

    assert_period_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (c_q.cnt == '0));

    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && $past(out_en)) |-> (tog_out != $past(tog_out)));

    assert_pw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse && ($past(mode) == 2'b11)) |-> (c_q.cnt == '0));

    assert_cap_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cnt_en) && $past(mode[1])) |-> (rd_data == '0));

    assert_no_match_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> !$past(mode[1]));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_pulse && cap_pulse));

endmodule

// File: tb/tmr_capcmp_test.sv
module tmr_capcmp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        cap_in = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic        batch_req = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] rd_data;
    logic        match_pulse, cap_pulse, tog_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap_cnt = 0;
    bit done   = 1'b0;

    tmr_capcmp uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
        .wr_en(wr_en), .wr_data(wr_data), .cap_in(cap_in),
        .edge_sel(edge_sel), .batch_req(batch_req), .out_en(out_en),
        .rd_data(rd_data), .match_pulse(match_pulse),
        .cap_pulse(cap_pulse), .tog_out(tog_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (cap_pulse) cap_cnt <= cap_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_match(output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (match_pulse) begin t = cyc; break; end
        end
        if (t < 0) begin
            checks++; fails++;
            $display("FAIL R2: actual no match expected match");
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic restart(input logic [1:0] m, input logic [1:0] es);
        @(negedge clk); cnt_en = 1'b0; cap_in = 1'b0;
        cycles(6);
        mode = m; edge_sel = es; cnt_en = 1'b1;
        cycles(6);
    endtask

    // drive cap_in to v, then read the register 6 clocks later
    task automatic edge_read(input logic v, output logic [15:0] r);
        cap_in = v;
        cycles(6);
        r = rd_data;
    endtask

    task automatic t_reset;
        cycles(2);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 match", match_pulse, 0);
        chk("R1 cap", cap_pulse, 0);
        chk("R1 tog", tog_out, 0);
    endtask

    task automatic t_interval;
        int t0, t1, t2, t3;
        logic tg;
        @(negedge clk); mode = 2'b00;
        write_reg(16'd9);
        out_en = 1'b1; cnt_en = 1'b1;
        wait_match(t0); wait_match(t1);
        chk("R2 period N=9", t1 - t0, 10);
        tg = tog_out;
        wait_match(t2);
        chk("R2 period repeat", t2 - t1, 10);
        chk("R3 toggle inverts", tog_out, !tg);
        out_en = 1'b0; tg = tog_out;
        wait_match(t3);
        chk("R3 toggle holds", tog_out, tg);
        // anytime write right after a match
        wr_en = 1'b1; wr_data = 16'd20;
        @(negedge clk); wr_en = 1'b0;
        wait_match(t0);
        chk("R4 anytime period", t0 - t3, 21);
        wait_match(t1);
        chk("R4 anytime steady", t1 - t0, 21);
    endtask

    task automatic t_batch;
        int t0, t1, t2, t3, t4, t5;
        @(negedge clk); cnt_en = 1'b0; mode = 2'b01;
        write_reg(16'd5);
        cnt_en = 1'b1;
        wait_match(t0); wait_match(t1);
        chk("R2 batch period N=5", t1 - t0, 6);
        write_reg(16'd12);
        chk("R5 readback", rd_data, 12);
        wait_match(t2); wait_match(t3);
        chk("R5 no strobe holds", t3 - t2, 6);
        batch_req = 1'b1;
        @(negedge clk); batch_req = 1'b0;
        wait_match(t4);
        chk("R5 current period kept", t4 - t3, 6);
        wait_match(t5);
        chk("R5 new period", t5 - t4, 13);
        @(negedge clk); cnt_en = 1'b0;
        cycles(3);
        chk("R6 kept on disable", rd_data, 12);
    endtask

    task automatic t_freecap;
        logic [15:0] a, b;
        int n0;
        restart(2'b10, 2'b01);
        edge_read(1'b1, a);
        cycles(4);
        n0 = cap_cnt;
        edge_read(1'b0, b);
        chk("R9 falling ignored on rise", cap_cnt - n0, 0);
        chk("R9 reg unchanged", b, a);
        cycles(27 - 6 - 4 - 6 + 20);
        edge_read(1'b1, b);
        // spacing between the two rises: 6+4+6+31 = 47
        chk("R7 free diff", 16'(b - a), 47);
        write_reg(16'h1234);
        chk("R13 write ignored", rd_data, b);
        // falling select
        edge_sel = 2'b10;
        edge_read(1'b0, a);
        cycles(14);
        edge_read(1'b1, b);
        chk("R9 rise ignored on fall", b, a);
        cycles(4);
        edge_read(1'b0, b);
        chk("R9 fall diff", 16'(b - a), 30);
        // none
        edge_sel = 2'b00; n0 = cap_cnt;
        edge_read(1'b1, a); edge_read(1'b0, a);
        chk("R9 none selected", cap_cnt - n0, 0);
        chk("R13 no match in capture", match_pulse, 0);
    endtask

    task automatic t_pulsew;
        logic [15:0] a, b;
        restart(2'b11, 2'b11);
        edge_read(1'b1, a);
        cycles(19);
        edge_read(1'b0, b);
        chk("R8 width both edges", b, 24);
        @(negedge clk); cnt_en = 1'b0;
        cycles(2);
        chk("R10 capture cleared", rd_data, 0);
    endtask

    task automatic t_wrap;
        logic [15:0] a, b;
        restart(2'b10, 2'b01);
        edge_read(1'b1, a);
        cycles(94);
        cap_in = 1'b0;
        cycles(65538 - 100);
        edge_read(1'b1, b);
        chk("R11 wrap diff", 16'(b - a), 2);
    endtask

    task automatic t_pw_long;
        logic [15:0] a, b;
        restart(2'b11, 2'b01);
        edge_read(1'b1, a);
        cycles(94);
        cap_in = 1'b0;
        cycles(65536 - 100);
        edge_read(1'b1, b);
        chk("R12 full width", b, 16'hFFFF);
        cycles(4);
        edge_read(1'b0, a);
        cycles(4);
        edge_read(1'b1, b);
        chk("R8 after long", b, 19);
    endtask

    initial begin
        cycles(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_interval;
        t_batch;
        t_freecap;
        t_pulsew;
        t_wrap;
        t_pw_long;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule